// File: doc/BRIEF.md
# 64-bit Integer ALU with Canonical 32-bit Word Operations

This block is the integer execution unit of a 64-bit core. It is purely combinational. It takes two register operands, a sign-extended immediate, an operation code and a flag that selects the immediate in place of the second register operand. From these it produces one 64-bit result in the same evaluation. It provides the full-width add, subtract, shifts, bitwise logic and signed and unsigned compares.

It also provides 32-bit word forms of add, add-immediate, subtract and the three shifts. A word operation looks only at the low half of its operands. It returns its 32-bit result with bit 31 copied across the upper half. As a result, every 32-bit quantity, signed or unsigned, stays in one canonical 64-bit form.

With that form, several things need no extra instruction: converting between signed and unsigned words, widening a signed word, and unsigned compares and bitwise logic on words.

Top module: `rv_word_alu`

## Requirements
- R1: With `b_use_imm`=0, op 0 returns `src_a + src_b` and op 1 returns `src_a - src_b`, both modulo 2^64; all-zero inputs give a zero result.
- R2: Ops 2, 3 and 4 (shift left, logical right, arithmetic right) shift all 64 bits of A by bits 5:0 of the B operand; the arithmetic form fills with bit 63.
- R3: Ops 5, 6 and 7 return A AND B, A OR B and A XOR B; when both inputs are canonical the output is canonical.
- R4: Ops 8 (signed) and 9 (unsigned) return 1 when A is less than B and 0 otherwise, in bit 0 with bits 63:1 clear; on canonical inputs op 9 orders the low 32 bits as unsigned numbers.
- R5: Ops 10 and 11 return the sign extension from bit 31 of the 32-bit sum or wrapped difference of the low halves; 0x7fffffff plus 1 gives 0xffffffff80000000.
- R6: Op 10 with `b_use_imm`=1 and a zero immediate returns the low 32 bits of A sign-extended, whatever A's upper half holds.
- R7: The word shifts (ops 12, 13, 14) use only bits 4:0 of the B operand as the amount; bit 5 and above have no effect.
- R8: Op 13 shifts the zero-filled low 32 bits of A right and then sign-extends bit 31 of that result; an amount of 0 returns the canonical form of A's low half.
- R9: Op 14 shifts the low 32 bits of A right, filling with A's bit 31 (not bit 63), and sign-extends the result.
- R10: Every word-operation result is canonical (bits 63:32 equal bit 31), and the upper halves of A and B never change it.
- R11: Op code 15 returns zero.
- R12: With `b_use_imm`=1 every operation uses `imm` in place of `src_b`, including as a shift amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (0..15, see requirements) |
| b_use_imm | input | 1 | 1 selects `imm` as the B operand, 0 selects `src_b` |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| imm | input | 64 | Sign-extended immediate |
| result | output | 64 | Operation result |

## Verification
The bench targets the boundaries where a word operation differs from its full-width form. These are the carry from 0x7fffffff into bit 31, the extension from bit 31 of a logically shifted word, an arithmetic word shift of a value whose bit 31 and bit 63 disagree, and shift amounts that have bit 5 set.

Each of these has a typical fault. A design that skips the final sign extension returns 0x0000000080000000 after the carry. One that fills from bit 63 shifts in zeros where it should shift in ones. One that decodes six amount bits for word shifts shifts too far. Random canonical operands then check that word results stay canonical, that logic results preserve the form, and that the unsigned compare orders the 32-bit values correctly.

// File: rtl/rv_word_alu.sv
module rv_word_alu #(
  parameter int XLEN = 64
) (
  input  logic [3:0]      op_sel,
  input  logic            b_use_imm,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] result
);
  localparam int WLEN = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);
  localparam int SHWW = $clog2(WLEN);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_SLL  = 4'd2;
  localparam logic [3:0] OP_SRL  = 4'd3;
  localparam logic [3:0] OP_SRA  = 4'd4;
  localparam logic [3:0] OP_AND  = 4'd5;
  localparam logic [3:0] OP_OR   = 4'd6;
  localparam logic [3:0] OP_XOR  = 4'd7;
  localparam logic [3:0] OP_SLT  = 4'd8;
  localparam logic [3:0] OP_SLTU = 4'd9;
  localparam logic [3:0] OP_ADDW = 4'd10;
  localparam logic [3:0] OP_SUBW = 4'd11;
  localparam logic [3:0] OP_SLLW = 4'd12;
  localparam logic [3:0] OP_SRLW = 4'd13;
  localparam logic [3:0] OP_SRAW = 4'd14;

  logic [XLEN-1:0] opb;
  logic [SHW-1:0]  amt;
  logic [SHWW-1:0] amt_w;
  logic [WLEN-1:0] aw, bw;

  assign opb   = b_use_imm ? imm : src_b;
  assign amt   = opb[SHW-1:0];
  assign amt_w = opb[SHWW-1:0];
  assign aw    = src_a[WLEN-1:0];
  assign bw    = opb[WLEN-1:0];

  logic [XLEN-1:0] sum, diff, sll_r, srl_r, sra_r;
  logic            lt_s, lt_u;

  assign sum   = src_a + opb;
  assign diff  = src_a - opb;
  assign sll_r = src_a << amt;
  assign srl_r = src_a >> amt;
  assign sra_r = $signed(src_a) >>> amt;
  assign lt_s  = $signed(src_a) < $signed(opb);
  assign lt_u  = src_a < opb;

  logic [WLEN-1:0] sum_w, diff_w, sll_w, srl_w, sra_w;

  assign sum_w  = aw + bw;
  assign diff_w = aw - bw;
  assign sll_w  = aw << amt_w;
  assign srl_w  = aw >> amt_w;
  assign sra_w  = $signed(aw) >>> amt_w;

  function automatic logic [XLEN-1:0] canon(input logic [WLEN-1:0] w);
    return {{(XLEN-WLEN){w[WLEN-1]}}, w};
  endfunction

  always_comb begin
    case (op_sel)
      OP_ADD:  result = sum;
      OP_SUB:  result = diff;
      OP_SLL:  result = sll_r;
      OP_SRL:  result = srl_r;
      OP_SRA:  result = sra_r;
      OP_AND:  result = src_a & opb;
      OP_OR:   result = src_a | opb;
      OP_XOR:  result = src_a ^ opb;
      OP_SLT:  result = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(XLEN-1){1'b0}}, lt_u};
      OP_ADDW: result = canon(sum_w);
      OP_SUBW: result = canon(diff_w);
      OP_SLLW: result = canon(sll_w);
      OP_SRLW: result = canon(srl_w);
      OP_SRAW: result = canon(sra_w);
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/rv_word_alu_chk.sv
module rv_word_alu_chk #(
  parameter int XLEN = 64
) (
  input logic [3:0]      op_sel,
  input logic            b_use_imm,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [XLEN-1:0] imm,
  input logic [XLEN-1:0] result
);
  localparam int WLEN = XLEN / 2;
  localparam int SHWW = $clog2(WLEN);

  logic [XLEN-1:0] opb;
  logic            word_op, logic_op, cmp_op, a_canon, b_canon, r_canon;

  assign opb      = b_use_imm ? imm : src_b;
  assign word_op  = (op_sel >= 4'd10) && (op_sel <= 4'd14);
  assign logic_op = (op_sel >= 4'd5) && (op_sel <= 4'd7);
  assign cmp_op   = (op_sel == 4'd8) || (op_sel == 4'd9);
  assign a_canon  = src_a[XLEN-1:WLEN] == {WLEN{src_a[WLEN-1]}};
  assign b_canon  = opb[XLEN-1:WLEN] == {WLEN{opb[WLEN-1]}};
  assign r_canon  = result[XLEN-1:WLEN] == {WLEN{result[WLEN-1]}};

  always_comb begin
    // R10
    a_r10_word_canonical: assert (!word_op || r_canon);
    // R3
    a_r3_logic_keeps_form: assert (!(logic_op && a_canon && b_canon) || r_canon);
    // R4
    a_r4_compare_boolean: assert (!cmp_op || result[XLEN-1:1] == '0);
    // R11
    a_r11_unused_zero: assert (op_sel != 4'd15 || result == '0);
    // R9
    a_r9_sraw_fill: assert (!(op_sel == 4'd14 && opb[SHWW-1:0] != '0) || result[WLEN-1] == src_a[WLEN-1]);
    // R6
    a_r6_addiw_zero: assert (!(op_sel == 4'd10 && b_use_imm && imm == '0) ||
                             result == {{WLEN{src_a[WLEN-1]}}, src_a[WLEN-1:0]});
  end
endmodule

bind rv_word_alu rv_word_alu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_rv_word_alu.sv
module tb_rv_word_alu;
  logic        clk = 1'b0;
  logic [3:0]  op_sel = '0;
  logic        b_use_imm = 1'b0;
  logic [63:0] src_a = '0, src_b = '0, imm = '0;
  logic [63:0] result;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  rv_word_alu dut (.op_sel(op_sel), .b_use_imm(b_use_imm), .src_a(src_a),
                   .src_b(src_b), .imm(imm), .result(result));

  function automatic logic [63:0] sx(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [63:0] model(input logic [3:0] op, input logic bs,
                                        input logic [63:0] a, input logic [63:0] b0,
                                        input logic [63:0] i);
    logic [63:0] b;
    logic [31:0] lo;
    b = bs ? i : b0;
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a << b[5:0];
      4'd3:  return a >> b[5:0];
      4'd4:  return 64'($signed(a) >>> b[5:0]);
      4'd5:  return a & b;
      4'd6:  return a | b;
      4'd7:  return a ^ b;
      4'd8:  return {63'd0, $signed(a) < $signed(b)};
      4'd9:  return {63'd0, a < b};
      4'd10: begin lo = a[31:0] + b[31:0]; return sx(lo); end
      4'd11: begin lo = a[31:0] - b[31:0]; return sx(lo); end
      4'd12: begin lo = a[31:0] << b[4:0]; return sx(lo); end
      4'd13: begin lo = a[31:0] >> b[4:0]; return sx(lo); end
      4'd14: begin lo = 32'($signed(a[31:0]) >>> b[4:0]); return sx(lo); end
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic bs, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] i);
    @(posedge clk);
    op_sel = op; b_use_imm = bs; src_a = a; src_b = b; imm = i;
    @(negedge clk);
  endtask

  task automatic dir(input string req, input logic [3:0] op, input logic bs,
                     input logic [63:0] a, input logic [63:0] b, input logic [63:0] i,
                     input logic [63:0] exp);
    apply(op, bs, a, b, i);
    check(req, result, exp);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    check("R1 reset zero", result, 64'd0);
    dir("R1 add", 4'd0, 1'b0, 64'h0000_0000_7fff_ffff, 64'd1, 64'd0, 64'h0000_0000_8000_0000);
    dir("R1 sub wrap", 4'd1, 1'b0, 64'd0, 64'd1, 64'd0, 64'hffff_ffff_ffff_ffff);
    dir("R5 addw carry", 4'd10, 1'b0, 64'h0000_0000_7fff_ffff, 64'd1, 64'd0, 64'hffff_ffff_8000_0000);
    dir("R5 subw wrap", 4'd11, 1'b0, 64'h0000_0000_8000_0000, 64'd1, 64'd0, 64'h0000_0000_7fff_ffff);
    dir("R6 addiw zero", 4'd10, 1'b1, 64'h1234_5678_89ab_cdef, 64'h55, 64'd0, 64'hffff_ffff_89ab_cdef);
    dir("R6 addiw zero pos", 4'd10, 1'b1, 64'hffff_0000_1234_5678, 64'h55, 64'd0, 64'h0000_0000_1234_5678);
    dir("R7 sllw bit5 ignored", 4'd12, 1'b0, 64'd1, 64'h21, 64'd0, 64'd2);
    dir("R2 sll 33", 4'd2, 1'b0, 64'd1, 64'h21, 64'd0, 64'h0000_0002_0000_0000);
    dir("R2 sra fill 63", 4'd4, 1'b0, 64'h8000_0000_0000_0000, 64'd4, 64'd0, 64'hf800_0000_0000_0000);
    dir("R2 sra low", 4'd4, 1'b0, 64'h0000_0000_8000_0000, 64'd4, 64'd0, 64'h0000_0000_0800_0000);
    dir("R8 srlw amt0", 4'd13, 1'b0, 64'hdead_beef_8000_0001, 64'd0, 64'd0, 64'hffff_ffff_8000_0001);
    dir("R8 srlw amt1", 4'd13, 1'b0, 64'hffff_ffff_8000_0000, 64'd1, 64'd0, 64'h0000_0000_4000_0000);
    dir("R9 sraw bit31", 4'd14, 1'b0, 64'h0000_0000_8000_0000, 64'd4, 64'd0, 64'hffff_ffff_f800_0000);
    dir("R9 sraw not bit63", 4'd14, 1'b0, 64'h8000_0000_4000_0000, 64'd4, 64'd0, 64'h0000_0000_0400_0000);
    dir("R10 subw upper ignored", 4'd11, 1'b0, 64'hffff_0000_0000_0000, 64'h1234_0000_0000_0001, 64'd0, 64'hffff_ffff_ffff_ffff);
    dir("R4 sltu canon big", 4'd9, 1'b0, 64'hffff_ffff_ffff_ffff, 64'd1, 64'd0, 64'd0);
    dir("R4 sltu canon small", 4'd9, 1'b0, 64'd1, 64'hffff_ffff_ffff_ffff, 64'd0, 64'd1);
    dir("R4 slt signed", 4'd8, 1'b0, 64'hffff_ffff_ffff_ffff, 64'd1, 64'd0, 64'd1);
    dir("R3 and", 4'd5, 1'b0, 64'hffff_ffff_f0f0_f0f0, 64'hffff_ffff_ff00_ff00, 64'd0, 64'hffff_ffff_f000_f000);
    dir("R3 xor", 4'd7, 1'b0, 64'hffff_ffff_8000_0000, 64'hffff_ffff_8000_0001, 64'd0, 64'd1);
    dir("R11 unused op", 4'd15, 1'b0, 64'h1234, 64'h5678, 64'd9, 64'd0);
    dir("R12 sub imm", 4'd1, 1'b1, 64'd10, 64'd1, 64'd3, 64'd7);
    dir("R12 sll imm amount", 4'd2, 1'b1, 64'd1, 64'd0, 64'd8, 64'h100);

    for (int k = 0; k < 4000; k++) begin
      logic [3:0]  op;
      logic        bs;
      logic [63:0] a, b, i, exp;
      logic [31:0] wa, wb;
      op = 4'($urandom_range(0, 15));
      bs = 1'($urandom());
      if (k % 2 == 0) begin
        a = sx($urandom()); b = sx($urandom()); i = sx($urandom());
      end else begin
        a = rnd64(); b = rnd64(); i = rnd64();
      end
      apply(op, bs, a, b, i);
      exp = model(op, bs, a, b, i);
      check("R12 random vs model", result, exp);
      if (op >= 4'd10 && op <= 4'd14)
        check("R10 word result canonical", result, sx(result[31:0]));
      if (k % 2 == 0 && op >= 4'd5 && op <= 4'd7)
        check("R3 logic keeps canonical", result, sx(result[31:0]));
      if (k % 2 == 0 && op == 4'd9) begin
        wa = a[31:0]; wb = (bs ? i[31:0] : b[31:0]);
        check("R4 sltu word order", result, {63'd0, wa < wb});
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule